// File: doc/BRIEF.md
# Phased Instruction Sequencer with Sector Search

This block is the control sequencer of a bit-serial, single-address machine whose main store is a rotating drum. There are 64 sectors per track and one 32-bit word per sector. The sequencer holds the program counter and the instruction register. It steps every command through four phases: a search for the command's sector, one word time that reads the command, a search for the operand's sector, and one word time of execution. While it does this it drives the head track select, the read and write enables and the phase code that the datapath uses to gate its own actions.

The drum's timing logic gives the sequencer one pulse per sector, `sec_tick`, at the end of the sector under the head. With the pulse comes `next_sector`, the number of the sector that is about to arrive, and `rd_data`, the word that has just been read from the selected track. A search phase arms a comparator with the wanted sector field. An exact match on a tick means the very next sector holds the wanted word. Each tick without a match simply rearms the search for the following sector.

The 12-bit address is made of a track field in bits 11:6 and a sector field in bits 5:0. A command word keeps its opcode in bits 15:12 and its address in bits 11:0.

Top module: `drum_phase_seq`

## Requirements
- R1: After a synchronous active-low reset the sequencer is in phase 0 (fetch search), the program counter is 0, `halted` is 0, and both `rd_en` and `wr_en` are 0.
- R2: In phase 0, `track_sel` shows bits 11:6 of the program counter. The sequencer moves to phase 1 (read) only on a tick whose `next_sector` equals bits 5:0 of the program counter.
- R3: Phase 1 lasts exactly one sector. On its closing tick, `ir_op` takes `rd_data[15:12]` and `ir_addr` takes `rd_data[11:0]`, and `rd_data[31:16]` is ignored. On the same tick the program counter increments by one.
- R4: In phase 2 (operand search), `track_sel` shows bits 11:6 of `ir_addr`. The sequencer moves to phase 3 (execute) only on a tick whose `next_sector` equals bits 5:0 of `ir_addr`.
- R5: Phase 3 lasts exactly one sector. Its closing tick returns the sequencer to phase 0.
- R6: With opcode 1010 (unconditional transfer), the closing tick of phase 3 loads `ir_addr` into the program counter.
- R7: With opcode 1011 (conditional transfer), the closing tick of phase 3 loads `ir_addr` into the program counter only if `acc_sign` is 1. Otherwise the counter keeps its value.
- R8: With opcode 0000 (stop), the closing tick of phase 1 sets `halted`. From then on, the program counter and all outputs stay frozen until reset.
- R9: `rd_en` is 1 in phase 1, and in phase 3 for opcodes that do not store. `wr_en` is 1 only in phase 3 for the store opcodes 1100, 1101, 0010 and 0011. The two enables are never 1 together.
- R10: A cycle without `sec_tick` changes neither the phase nor the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse at the end of each sector |
| next_sector | input | 6 | Number of the sector that follows, valid with `sec_tick` |
| rd_data | input | 32 | Word just read from the selected track, valid with `sec_tick` |
| acc_sign | input | 1 | Accumulator sign, 1 = negative |
| track_sel | output | 6 | Head track select |
| rd_en | output | 1 | Read the sector under the head |
| wr_en | output | 1 | Record into the sector under the head |
| phase_o | output | 2 | 0 fetch search, 1 read, 2 operand search, 3 execute |
| halted | output | 1 | Stopped by opcode 0000 |
| pc_o | output | 12 | Program counter |
| ir_op | output | 4 | Opcode held in the instruction register |
| ir_addr | output | 12 | Address held in the instruction register |

## Verification
The properties assume that `sec_tick` is a single-cycle pulse, with several idle cycles between pulses, as the sector timing track guarantees. They also assume that `next_sector` and `acc_sign` are steady whenever they are sampled on a tick. The bench builds a drum model that advances one sector every four clocks and announces sector numbers in rotating order. It changes the accumulator sign only between commands, so every search and every transfer decision sees stable inputs. Command words carry nonzero filler in their ignored upper bits to show that only the opcode and address fields matter.

// File: rtl/drum_seq_pkg.sv
// Shared definitions for the drum phase sequencer: phase encoding,
// command word field positions and opcode classes.
// Assumes a 4-bit opcode directly above a 12-bit address field.
package drum_seq_pkg;
    typedef enum logic [2:0] {
        PH_FETCH  = 3'b000,
        PH_READ   = 3'b001,
        PH_OPSRCH = 3'b010,
        PH_EXEC   = 3'b011,
        PH_HALT   = 3'b100
    } phase_t;

    localparam int OP_W   = 4;
    localparam int OP_LSB = 12;

    localparam logic [OP_W-1:0] OP_STOP = 4'b0000;
    localparam logic [OP_W-1:0] OP_JUMP = 4'b1010;
    localparam logic [OP_W-1:0] OP_BRNG = 4'b1011;

    // True for the opcodes that record the accumulator into the drum.
    function automatic logic op_writes(input logic [OP_W-1:0] op);
        return (op == 4'b1100) || (op == 4'b1101) ||
               (op == 4'b0010) || (op == 4'b0011);
    endfunction
endpackage

// File: rtl/seq_sector_cmp.sv
// Sector coincidence detector: flags a hit when a search is armed and
// the announced next-sector number equals the wanted sector field on a
// sector tick. Assumes the announcement is valid only with the tick.
module seq_sector_cmp #(
    parameter int SEC_W = 6
) (
    input  logic             tick,
    input  logic             arm,
    input  logic [SEC_W-1:0] want,
    input  logic [SEC_W-1:0] announced,
    output logic             hit
);
    // Exact coincidence only; a miss leaves the search armed for the next tick.
    always_comb begin
        hit = tick && arm && (want == announced);
    end
endmodule

// File: rtl/seq_pc_reg.sv
// Program counter: increments when used for a fetch, loads a transfer
// address on a taken branch. Assumes inc and load are never both high.
module seq_pc_reg #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] pc
);
    // Counter update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (load) begin
            pc <= load_val;
        end else if (inc) begin
            pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/drum_phase_seq.sv
// Four-phase command sequencer for a drum-store serial machine.
// Fetch search -> read (one sector) -> operand search -> execute (one
// sector) -> fetch search. Searches compare a sector field with the
// announced next-sector number on each sector tick. A stop opcode
// freezes the sequencer until reset. Assumes sec_tick is a one-cycle
// pulse separated by idle cycles.
module drum_phase_seq
    import drum_seq_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int TRK_W  = 6,
    parameter int SEC_W  = 6,
    localparam int ADDR_W = TRK_W + SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [SEC_W-1:0]  next_sector,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              acc_sign,
    output logic [TRK_W-1:0]  track_sel,
    output logic              rd_en,
    output logic              wr_en,
    output logic [1:0]        phase_o,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_o,
    output logic [OP_W-1:0]   ir_op,
    output logic [ADDR_W-1:0] ir_addr
);
    localparam int OP_MSB = OP_LSB + OP_W - 1;

    phase_t             state, state_nx;
    logic               hit;
    logic               arm;
    logic [SEC_W-1:0]   want_sec;
    logic               pc_inc, pc_load;
    logic [OP_W-1:0]    fetched_op;
    logic               unused_hi_bits;

    assign fetched_op     = rd_data[OP_MSB:OP_LSB];
    assign unused_hi_bits = ^rd_data[WORD_W-1:OP_MSB+1];

    // Select which address feeds the comparator in each search phase.
    always_comb begin
        arm      = (state == PH_FETCH) || (state == PH_OPSRCH);
        want_sec = (state == PH_FETCH) ? pc_o[SEC_W-1:0] : ir_addr[SEC_W-1:0];
    end

    seq_sector_cmp #(.SEC_W(SEC_W)) u_cmp (
        .tick      (sec_tick),
        .arm       (arm),
        .want      (want_sec),
        .announced (next_sector),
        .hit       (hit)
    );

    // Counter controls: bump when the fetch word is consumed, load on taken transfer.
    always_comb begin
        pc_inc  = sec_tick && (state == PH_READ);
        pc_load = sec_tick && (state == PH_EXEC) &&
                  ((ir_op == OP_JUMP) || ((ir_op == OP_BRNG) && acc_sign));
    end

    seq_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (pc_inc),
        .load     (pc_load),
        .load_val (ir_addr),
        .pc       (pc_o)
    );

    // Phase transitions, all taken on a sector tick.
    always_comb begin
        state_nx = state;
        if (sec_tick) begin
            case (state)
                PH_FETCH:  if (hit) state_nx = PH_READ;
                PH_READ:   state_nx = (fetched_op == OP_STOP) ? PH_HALT : PH_OPSRCH;
                PH_OPSRCH: if (hit) state_nx = PH_EXEC;
                PH_EXEC:   state_nx = PH_FETCH;
                default:   state_nx = PH_HALT;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_FETCH;
        else        state <= state_nx;
    end

    // Instruction register: captures opcode and address at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_op   <= '0;
            ir_addr <= '0;
        end else if (sec_tick && (state == PH_READ)) begin
            ir_op   <= fetched_op;
            ir_addr <= rd_data[ADDR_W-1:0];
        end
    end

    // Track select register: follows the address being searched for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track_sel <= '0;
        end else if (state == PH_FETCH) begin
            track_sel <= pc_o[ADDR_W-1:SEC_W];
        end else if (state == PH_OPSRCH) begin
            track_sel <= ir_addr[ADDR_W-1:SEC_W];
        end
    end

    // Head enables and phase code for the datapath.
    always_comb begin
        rd_en   = (state == PH_READ) || ((state == PH_EXEC) && !op_writes(ir_op));
        wr_en   = (state == PH_EXEC) && op_writes(ir_op);
        phase_o = state[1:0];
        halted  = (state == PH_HALT);
    end
endmodule

// File: rtl/drum_phase_seq_chk.sv
// Checker for drum_phase_seq: temporal properties over its ports.
// Assumes sec_tick pulses last one cycle.
module drum_phase_seq_chk #(
    parameter int TRK_W  = 6,
    parameter int SEC_W  = 6,
    localparam int ADDR_W = TRK_W + SEC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic [SEC_W-1:0]  next_sector,
    input logic              acc_sign,
    input logic              rd_en,
    input logic              wr_en,
    input logic [1:0]        phase_o,
    input logic              halted,
    input logic [ADDR_W-1:0] pc_o,
    input logic [3:0]        ir_op,
    input logic [ADDR_W-1:0] ir_addr
);
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> ($stable(phase_o) && $stable(pc_o)));

    a_r2_no_false_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && phase_o == 2'd0 && sec_tick && next_sector != pc_o[SEC_W-1:0])
        |=> (phase_o == 2'd0));

    a_r3_pc_bump: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1 && sec_tick) |=> (pc_o == $past(pc_o) + 1'b1));

    a_r4_no_false_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && sec_tick && next_sector != ir_addr[SEC_W-1:0])
        |=> (phase_o == 2'd2));

    a_r5_exec_one_sector: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && sec_tick) |=> (phase_o == 2'd0 && !halted));

    a_r6_jump_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && sec_tick && ir_op == 4'b1010) |=> (pc_o == $past(ir_addr)));

    a_r7_branch_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && sec_tick && ir_op == 4'b1011 && !acc_sign) |=> $stable(pc_o));

    a_r8_halt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_o) && !rd_en && !wr_en));

    // R9: enables are exclusive
    always_comb begin
        if (rst_n) a_r9_enables_exclusive: assert (!(rd_en && wr_en));
    end
endmodule

bind drum_phase_seq drum_phase_seq_chk #(.TRK_W(TRK_W), .SEC_W(SEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .next_sector (next_sector),
    .acc_sign    (acc_sign),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .phase_o     (phase_o),
    .halted      (halted),
    .pc_o        (pc_o),
    .ir_op       (ir_op),
    .ir_addr     (ir_addr)
);

// File: tb/drum_phase_seq_tb_top.sv
// Bench: a drum model advancing one sector every SUB clocks runs a small
// program described by a vector table; directed checks cover reset,
// idle cycles and the stop opcode.
module drum_phase_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SUB        = 4;
    localparam int NVEC       = 7;
    localparam int WATCHDOG   = 150000;

    // {fetch_addr[41:30], op[29:26], opnd_addr[25:14], sign[13], store[12], exp_pc[11:0]}
    localparam logic [41:0] VEC [NVEC] = '{
        {12'h000, 4'hE, 12'h005, 1'b0, 1'b0, 12'h001},
        {12'h001, 4'hA, 12'h008, 1'b0, 1'b0, 12'h008},
        {12'h008, 4'hB, 12'h00C, 1'b0, 1'b0, 12'h009},
        {12'h009, 4'hB, 12'h003, 1'b1, 1'b0, 12'h003},
        {12'h003, 4'hC, 12'h0C7, 1'b0, 1'b1, 12'h004},
        {12'h004, 4'hA, 12'h041, 1'b0, 1'b0, 12'h041},
        {12'h041, 4'h0, 12'h000, 1'b0, 1'b0, 12'h042}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [5:0]  next_sector = '0;
    logic [31:0] rd_data = '0;
    logic        acc_sign = 1'b0;
    logic [5:0]  track_sel;
    logic        rd_en, wr_en, halted;
    logic [1:0]  phase_o;
    logic [11:0] pc_o, ir_addr;
    logic [3:0]  ir_op;

    logic drum_run = 1'b0;
    int   cur_sec = 63;
    int   sub_cnt = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    drum_phase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .next_sector(next_sector),
        .rd_data(rd_data), .acc_sign(acc_sign), .track_sel(track_sel),
        .rd_en(rd_en), .wr_en(wr_en), .phase_o(phase_o), .halted(halted),
        .pc_o(pc_o), .ir_op(ir_op), .ir_addr(ir_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Drum contents: program words from the table with filler in the ignored bits.
    function automatic logic [31:0] drum_word(input logic [11:0] addr);
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][41:30] == addr) return {16'hA5A5, VEC[i][29:26], VEC[i][25:14]};
        end
        return 32'h5A5A_F123;
    endfunction

    // Drum model: one tick at the last clock of each sector.
    always @(negedge clk) begin
        if (!drum_run) begin
            sec_tick <= 1'b0;
        end else if (sub_cnt == SUB-1) begin
            sec_tick    <= 1'b1;
            next_sector <= 6'((cur_sec + 1) % 64);
            rd_data     <= drum_word({track_sel, 6'(cur_sec)});
            cur_sec     = (cur_sec + 1) % 64;
            sub_cnt     = 0;
        end else begin
            sec_tick <= 1'b0;
            sub_cnt  = sub_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_phase(input logic [1:0] ph);
        do step(); while (phase_o != ph);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        logic [11:0] fa, oa, ex, pc_hold;
        logic [3:0]  op;
        logic        sg, st;

        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 phase", 32'(phase_o), 32'd0);
        chk("R1 pc", 32'(pc_o), 32'd0);
        chk("R1 halted", 32'(halted), 32'd0);
        chk("R1 rd_en", 32'(rd_en), 32'd0);
        chk("R1 wr_en", 32'(wr_en), 32'd0);
        // R10: no ticks, nothing moves
        repeat (12) step();
        chk("R10 phase idle", 32'(phase_o), 32'd0);
        chk("R10 pc idle", 32'(pc_o), 32'd0);

        drum_run = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            fa = VEC[i][41:30]; op = VEC[i][29:26]; oa = VEC[i][25:14];
            sg = VEC[i][13];    st = VEC[i][12];    ex = VEC[i][11:0];
            acc_sign = sg;
            wait_phase(2'd1);
            chk("R2 fetch sector", 32'(cur_sec), 32'(fa[5:0]));
            chk("R2 fetch track", 32'(track_sel), 32'(fa[11:6]));
            chk("R9 rd_en read", 32'(rd_en), 32'd1);
            n = 0;
            do begin step(); n++; end while (phase_o == 2'd1 && !halted);
            chk("R3 read one sector", 32'(n), 32'(SUB));
            chk("R3 ir_op", 32'(ir_op), 32'(op));
            chk("R3 pc bump", 32'(pc_o), 32'(fa + 12'd1));
            if (op == 4'h0) begin
                chk("R8 halted", 32'(halted), 32'd1);
                chk("R8 pc", 32'(pc_o), 32'(ex));
                pc_hold = pc_o;
                repeat (300) step();
                chk("R8 stays halted", 32'(halted), 32'd1);
                chk("R8 pc frozen", 32'(pc_o), 32'(pc_hold));
                chk("R8 enables off", 32'({rd_en, wr_en}), 32'd0);
            end else begin
                chk("R3 ir_addr ignores high bits", 32'(ir_addr), 32'(oa));
                wait_phase(2'd3);
                chk("R4 operand sector", 32'(cur_sec), 32'(oa[5:0]));
                chk("R4 operand track", 32'(track_sel), 32'(oa[11:6]));
                chk("R9 wr_en exec", 32'(wr_en), 32'(st));
                chk("R9 rd_en exec", 32'(rd_en), 32'(!st));
                n = 0;
                do begin step(); n++; end while (phase_o == 2'd3);
                chk("R5 exec one sector", 32'(n), 32'(SUB));
                chk("R5 back to fetch", 32'(phase_o), 32'd0);
                if (op == 4'hA)      chk("R6 jump pc", 32'(pc_o), 32'(ex));
                else if (op == 4'hB) chk("R7 branch pc", 32'(pc_o), 32'(ex));
                else                 chk("R5 sequential pc", 32'(pc_o), 32'(ex));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule